// File: doc/BRIEF.md
# Three-Line Handshake Byte Transfer Engine

This block moves single bytes between a host and a device-side packet buffer using three active-low handshake lines and one 8-bit shift data register. The host owns two lines: a busy line that frames a whole transfer and an acknowledge line that paces the bytes. The block drives the third line, a request line. It uses that line both to say that response bytes are waiting and to say that the last response byte has been handed over. There is no serial clock. A byte moves whenever the host changes the level of its busy/acknowledge pair while busy is asserted.

A direction input selects the transfer direction. When it is 1, the host writes a byte into the shift register and toggles the pair, and the block appends that byte to a collection buffer. When the host releases busy, the block reports the finished packet with a one-cycle completion strobe that carries the byte count. When the direction input is 0, each pair change moves the next queued response byte into the shift register, where the host reads it.

Every handshake step also schedules a shift-register interrupt pulse. The pulse is delayed by a parameterised number of cycles, and a new step restarts the delay. The pulse is instead issued without delay when the handshake port's direction mask reads all ones.

Top module: `hsx_engine`

## Requirements
- R1: After reset, dev_req_n is 1, sr_q is 0x00, and sr_irq and pkt_done are 0.
- R2: With host_busy_n at 0 and dir_out at 1, each clock on which the pair {host_busy_n, host_ack_n} differs from its previous sample stores the current sr_q into the next collection slot, starting at slot 0. The slot is readable on obuf_rdata at address obuf_raddr. Once OUT_DEPTH slots are full, further bytes are dropped and trigger no interrupt.
- R3: With host_busy_n at 0, dir_out at 0 and response bytes unread, each pair change loads the next response byte into sr_q. When the last byte is taken, dev_req_n goes to 1. A pair change with no unread byte changes nothing.
- R4: When host_busy_n is 1 on this sample and was 1 on the previous sample, a change of host_ack_n copies the new host_ack_n level onto dev_req_n and triggers an interrupt.
- R5: When host_busy_n goes from 0 to 1, an interrupt is always triggered. If at least one byte was collected, pkt_done pulses for one cycle and pkt_len carries the count. The count returns to zero in the same cycle. pkt_len holds the last reported count between strobes.
- R6: On any clock where host_busy_n is 1 and R4 does not apply, dev_req_n is driven to 0 if response bytes remain unread.
- R7: When hs_dir_mask is not 0xFF, sr_irq pulses for one cycle DELAY_CYC clocks after the triggering sample. A trigger that arrives while a delay is running restarts the delay.
- R8: When hs_dir_mask equals 0xFF, sr_irq pulses on the clock right after the triggering sample, and any running delay is cancelled.
- R9: rsp_go commits rsp_len bytes, which were written earlier through rsp_we/rsp_waddr/rsp_wdata, as the new response. It resets the read position to the first byte and triggers an interrupt. rsp_go takes precedence over a same-cycle read advance.
- R10: sr_we writes sr_wdata into sr_q on the next clock, unless a response byte is loaded on that same clock; the response byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_busy_n | input | 1 | Host transfer framing line, active low |
| host_ack_n | input | 1 | Host byte pacing line, active low |
| dev_req_n | output | 1 | Device request / end-of-response line, active low |
| dir_out | input | 1 | 1 = host sends bytes, 0 = host receives bytes |
| hs_dir_mask | input | 8 | Handshake port direction mask; 0xFF selects undelayed interrupts |
| sr_we | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Host write data for the shift register |
| sr_q | output | 8 | Shift register contents |
| obuf_raddr | input | $clog2(OUT_DEPTH) | Collection buffer read address |
| obuf_rdata | output | 8 | Collection buffer read data |
| pkt_done | output | 1 | One-cycle end-of-packet strobe |
| pkt_len | output | $clog2(OUT_DEPTH+1) | Byte count of the last completed packet |
| rsp_we | input | 1 | Response buffer write strobe |
| rsp_waddr | input | $clog2(RSP_DEPTH) | Response buffer write address |
| rsp_wdata | input | 8 | Response buffer write data |
| rsp_go | input | 1 | Commit a new response |
| rsp_len | input | $clog2(RSP_DEPTH+1) | Length of the committed response |
| sr_irq | output | 1 | Shift-register interrupt pulse |

## Verification
dev_req_n, sr_q, pkt_done and pkt_len are registered, so each one changes on the first clock edge that samples the causing input. The bench therefore expects them one cycle after its stimulus. sr_irq follows a trigger by DELAY_CYC edges in delayed mode and by one edge in undelayed mode. A behavioural model updates on each rising edge from the same sampled inputs. Every output is compared against that model 2 ns after the edge. Stimulus changes only on falling edges, and the directed checks read at falling edges that lie a known number of edges after the stimulus.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] DIR_ALL_OUT = 8'hFF;

   typedef logic [BYTE_W-1:0] byte_t;

   // handshake events decoded from one sample of the host lines
   typedef struct packed {
      logic put;   // host-to-device byte step
      logic get;   // device-to-host byte step
      logic sync;  // ack toggle while idle
      logic fin;   // busy released
      logic idle;  // busy released, no ack toggle rule
   } hs_ev_t;
endpackage

// File: rtl/hsx_pair_track.sv
module hsx_pair_track (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_n_i,
   input  logic ack_n_i,
   output logic busy_prev_n,
   output logic pair_chg,
   output logic ack_chg
);
   logic busy_q;
   logic ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         ack_q  <= 1'b1;
      end else begin
         busy_q <= busy_n_i;
         ack_q  <= ack_n_i;
      end
   end

   assign busy_prev_n = busy_q;
   assign ack_chg     = ack_n_i != ack_q;
   assign pair_chg    = ack_chg || (busy_n_i != busy_q);
endmodule

// File: rtl/hsx_collect.sv
module hsx_collect
   import hsx_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       put,
   input  byte_t                      din,
   input  logic                       flush,
   input  logic [$clog2(DEPTH)-1:0]   raddr,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       stored,
   output byte_t                      rdata
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0]        cnt_q;
   logic [DEPTH-1:0][BYTE_W-1:0] slots;

   assign stored = put && (cnt_q < CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (flush)  cnt_q <= '0;
      else if (stored) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= '0;
         else if (stored && cnt_q == CW'(g)) q <= din;
      end
      assign slots[g] = q;
   end

   assign count = cnt_q;
   assign rdata = slots[raddr];
endmodule

// File: rtl/hsx_feed.sv
module hsx_feed
   import hsx_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(DEPTH)-1:0]   waddr,
   input  byte_t                      wdata,
   input  logic                       go,
   input  logic [$clog2(DEPTH+1)-1:0] len,
   input  logic                       take,
   output logic                       pending,
   output logic                       last,
   output byte_t                      head
);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [CW-1:0] size_q;
   logic [CW-1:0] rd_q;
   logic [DEPTH-1:0][BYTE_W-1:0] cells;

   assign pending = rd_q < size_q;
   assign last    = pending && (rd_q == size_q - 1'b1);
   assign head    = cells[rd_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         rd_q   <= '0;
      end else if (go) begin
         size_q <= (len > CW'(DEPTH)) ? CW'(DEPTH) : len;
         rd_q   <= '0;
      end else if (take) begin
         rd_q <= rd_q + 1'b1;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= '0;
         else if (we && waddr == AW'(g))     q <= wdata;
      end
      assign cells[g] = q;
   end
endmodule

// File: rtl/hsx_irq_delay.sv
module hsx_irq_delay #(
   parameter int unsigned DELAY_CYC = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic imm,
   output logic pulse
);
   if (DELAY_CYC == 0) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse <= 1'b0;
         else        pulse <= trig;
      end
   end else begin : g_timed
      localparam int unsigned DW = $clog2(DELAY_CYC + 1);
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
         end else if (trig && imm) begin
            cnt_q <= '0;
            pulse <= 1'b1;
         end else if (trig) begin
            cnt_q <= DW'(DELAY_CYC);
            pulse <= 1'b0;
         end else if (cnt_q == DW'(1)) begin
            cnt_q <= '0;
            pulse <= 1'b1;
         end else begin
            cnt_q <= (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
            pulse <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hsx_engine.sv
module hsx_engine
   import hsx_pkg::*;
#(
   parameter int unsigned OUT_DEPTH = 16,
   parameter int unsigned RSP_DEPTH = 16,
   parameter int unsigned DELAY_CYC = 15000
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            host_busy_n,
   input  logic                            host_ack_n,
   output logic                            dev_req_n,
   input  logic                            dir_out,
   input  logic [7:0]                      hs_dir_mask,
   input  logic                            sr_we,
   input  logic [7:0]                      sr_wdata,
   output logic [7:0]                      sr_q,
   input  logic [$clog2(OUT_DEPTH)-1:0]    obuf_raddr,
   output logic [7:0]                      obuf_rdata,
   output logic                            pkt_done,
   output logic [$clog2(OUT_DEPTH+1)-1:0]  pkt_len,
   input  logic                            rsp_we,
   input  logic [$clog2(RSP_DEPTH)-1:0]    rsp_waddr,
   input  logic [7:0]                      rsp_wdata,
   input  logic                            rsp_go,
   input  logic [$clog2(RSP_DEPTH+1)-1:0]  rsp_len,
   output logic                            sr_irq
);
   localparam int unsigned OCW = $clog2(OUT_DEPTH + 1);

   if (OUT_DEPTH < 2) begin : g_bad_out
      $error("OUT_DEPTH must be at least 2");
   end
   if (RSP_DEPTH < 2) begin : g_bad_rsp
      $error("RSP_DEPTH must be at least 2");
   end

   logic     busy_prev_n, pair_chg, ack_chg;
   logic     tip_on;
   hs_ev_t   ev;
   logic     stored, rsp_pend, rsp_last, trig;
   byte_t    rsp_head;
   logic [OCW-1:0] ocount;

   byte_t          sr_r;
   logic           req_r;
   logic           done_r;
   logic [OCW-1:0] len_r;

   hsx_pair_track u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_n_i   (host_busy_n),
      .ack_n_i    (host_ack_n),
      .busy_prev_n(busy_prev_n),
      .pair_chg   (pair_chg),
      .ack_chg    (ack_chg)
   );

   assign tip_on = !host_busy_n;

   always_comb begin
      ev      = '0;
      ev.put  = tip_on && pair_chg && dir_out;
      ev.get  = tip_on && pair_chg && !dir_out && rsp_pend;
      ev.sync = !tip_on && busy_prev_n && ack_chg;
      ev.fin  = !tip_on && !busy_prev_n;
      ev.idle = !tip_on && !ev.sync;
   end

   hsx_collect #(.DEPTH(OUT_DEPTH)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .put   (ev.put),
      .din   (sr_r),
      .flush (ev.fin),
      .raddr (obuf_raddr),
      .count (ocount),
      .stored(stored),
      .rdata (obuf_rdata)
   );

   hsx_feed #(.DEPTH(RSP_DEPTH)) u_feed (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rsp_we),
      .waddr  (rsp_waddr),
      .wdata  (rsp_wdata),
      .go     (rsp_go),
      .len    (rsp_len),
      .take   (ev.get),
      .pending(rsp_pend),
      .last   (rsp_last),
      .head   (rsp_head)
   );

   assign trig = stored || ev.get || ev.sync || ev.fin || rsp_go;

   hsx_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (trig),
      .imm  (hs_dir_mask == DIR_ALL_OUT),
      .pulse(sr_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_r <= '0;
      else if (ev.get) sr_r <= rsp_head;
      else if (sr_we)  sr_r <= sr_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      req_r <= 1'b1;
      else if (ev.get && rsp_last)     req_r <= 1'b1;
      else if (ev.sync)                req_r <= host_ack_n;
      else if (ev.idle && rsp_pend)    req_r <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_r <= 1'b0;
         len_r  <= '0;
      end else begin
         done_r <= ev.fin && (ocount != '0);
         if (ev.fin && (ocount != '0)) len_r <= ocount;
      end
   end

   assign sr_q      = sr_r;
   assign dev_req_n = req_r;
   assign pkt_done  = done_r;
   assign pkt_len   = len_r;
endmodule

// File: rtl/hsx_engine_chk.sv
module hsx_engine_chk #(
   parameter int unsigned OUT_DEPTH = 16
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           host_busy_n,
   input logic                           host_ack_n,
   input logic                           dev_req_n,
   input logic [7:0]                     hs_dir_mask,
   input logic                           rsp_go,
   input logic                           pkt_done,
   input logic [$clog2(OUT_DEPTH+1)-1:0] pkt_len,
   input logic                           sr_irq
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R5: completion strobe lasts a single cycle
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |=> !pkt_done);

   // R5: a strobe never reports an empty packet
   p_done_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> pkt_len != '0);

   // R2: reported count never exceeds the buffer
   p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_len <= ($clog2(OUT_DEPTH+1))'(OUT_DEPTH));

   // R4: idle ack toggle is mirrored on the request line
   p_sync_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && host_busy_n && $past(host_busy_n) && host_ack_n != $past(host_ack_n))
      |=> dev_req_n == $past(host_ack_n));

   // R8: undelayed interrupt after a response commit
   p_imm_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_go && hs_dir_mask == 8'hFF) |=> sr_irq);
endmodule

bind hsx_engine hsx_engine_chk #(.OUT_DEPTH(OUT_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_busy_n(host_busy_n),
   .host_ack_n (host_ack_n),
   .dev_req_n  (dev_req_n),
   .hs_dir_mask(hs_dir_mask),
   .rsp_go     (rsp_go),
   .pkt_done   (pkt_done),
   .pkt_len    (pkt_len),
   .sr_irq     (sr_irq)
);

// File: tb/tb_hsx_engine.sv
`timescale 1ns/1ps
module tb_hsx_engine;
   localparam int DEPTH = 16;
   localparam int DLY   = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_busy_n = 1'b1, host_ack_n = 1'b1, dir_out = 1'b0;
   logic [7:0] hs_dir_mask = 8'h30;
   logic sr_we = 1'b0;
   logic [7:0] sr_wdata = 8'h00;
   logic [3:0] obuf_raddr = '0;
   logic rsp_we = 1'b0, rsp_go = 1'b0;
   logic [3:0] rsp_waddr = '0;
   logic [7:0] rsp_wdata = '0;
   logic [4:0] rsp_len = '0;
   logic dev_req_n, pkt_done, sr_irq;
   logic [7:0] sr_q, obuf_rdata;
   logic [4:0] pkt_len;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   hsx_engine #(.OUT_DEPTH(DEPTH), .RSP_DEPTH(DEPTH), .DELAY_CYC(DLY)) dut (
      .clk(clk), .rst_n(rst_n), .host_busy_n(host_busy_n), .host_ack_n(host_ack_n),
      .dev_req_n(dev_req_n), .dir_out(dir_out), .hs_dir_mask(hs_dir_mask),
      .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_q(sr_q), .obuf_raddr(obuf_raddr),
      .obuf_rdata(obuf_rdata), .pkt_done(pkt_done), .pkt_len(pkt_len),
      .rsp_we(rsp_we), .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata),
      .rsp_go(rsp_go), .rsp_len(rsp_len), .sr_irq(sr_irq));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_busy, m_ack, m_cnt, m_rsize, m_rd, m_sr, m_req, m_done, m_len, m_irq, m_dcnt;
   int m_obuf[DEPTH];
   int m_rsp[DEPTH];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1; m_ack = 1; m_cnt = 0; m_rsize = 0; m_rd = 0; m_sr = 0;
         m_req = 1; m_done = 0; m_len = 0; m_irq = 0; m_dcnt = 0;
         foreach (m_obuf[i]) begin m_obuf[i] = 0; m_rsp[i] = 0; end
      end else begin
         bit chg, trig, pend, busy_on;
         int old_sr;
         busy_on = (host_busy_n == 1'b0);
         chg  = (host_busy_n != m_busy) || (host_ack_n != m_ack);
         pend = m_rd < m_rsize;
         trig = 0;
         old_sr = m_sr;
         m_done = 0;
         if (busy_on) begin
            if (chg && dir_out) begin
               if (m_cnt < DEPTH) begin m_obuf[m_cnt] = old_sr; m_cnt++; trig = 1; end
            end else if (chg && pend) begin
               m_sr = m_rsp[m_rd];
               if (m_rd + 1 == m_rsize) m_req = 1;
               m_rd++;
               trig = 1;
            end
         end else if (m_busy == 1 && host_ack_n != m_ack) begin
            m_req = host_ack_n;
            trig = 1;
         end else begin
            if (m_busy == 0) begin
               trig = 1;
               if (m_cnt > 0) begin m_done = 1; m_len = m_cnt; end
               m_cnt = 0;
            end
            if (pend) m_req = 0;
         end
         if (!(busy_on && chg && !dir_out && pend) && sr_we) m_sr = sr_wdata;
         if (rsp_we) m_rsp[rsp_waddr] = rsp_wdata;
         if (rsp_go) begin m_rsize = (rsp_len > DEPTH) ? DEPTH : rsp_len; m_rd = 0; trig = 1; end
         if (trig && hs_dir_mask == 8'hFF) begin m_irq = 1; m_dcnt = 0; end
         else if (trig) begin m_irq = 0; m_dcnt = DLY; end
         else if (m_dcnt == 1) begin m_irq = 1; m_dcnt = 0; end
         else begin m_irq = 0; if (m_dcnt > 0) m_dcnt--; end
         m_busy = host_busy_n;
         m_ack  = host_ack_n;
      end
   end

   // compare every output 2 ns after each rising edge
   always begin
      @(posedge clk);
      #2;
      if (rst_n && !finished) begin
         check(dev_req_n == m_req[0], "R4 R6 dev_req_n", dev_req_n, m_req);
         check(sr_q == m_sr[7:0], "R3 sr_q", sr_q, m_sr);
         check(sr_irq == m_irq[0], "R7 sr_irq", sr_irq, m_irq);
         check(pkt_done == m_done[0], "R5 pkt_done", pkt_done, m_done);
         check(pkt_len == m_len[4:0], "R5 pkt_len", pkt_len, m_len);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic nclk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_sr(input logic [7:0] v);
      @(negedge clk); sr_we = 1'b1; sr_wdata = v;
      @(negedge clk); sr_we = 1'b0;
   endtask

   task automatic obuf_expect(input int addr, input int exp);
      obuf_raddr = addr[3:0];
      #1;
      check(obuf_rdata == exp[7:0], "R2 obuf", obuf_rdata, exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      nclk(100000);
      if (!finished) begin
         finished = 1;
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      nclk(3);
      rst_n = 1'b1;
      nclk(1);
      // R1 reset state
      check(dev_req_n == 1'b1, "R1 dev_req_n", dev_req_n, 1);
      check(sr_q == 8'h00, "R1 sr_q", sr_q, 0);
      check(sr_irq == 1'b0 && pkt_done == 1'b0, "R1 pulses", {sr_irq, pkt_done}, 0);

      // R10 host write of shift register
      write_sr(8'h5A);
      check(sr_q == 8'h5A, "R10 sr write", sr_q, 8'h5A);

      // R2 host-to-device packet of three bytes
      dir_out = 1'b1;
      write_sr(8'hA1);
      host_busy_n = 1'b0;
      nclk(2);
      write_sr(8'hA2);
      host_ack_n = 1'b0;
      nclk(2);
      write_sr(8'hA3);
      host_ack_n = 1'b1;
      nclk(2);
      host_busy_n = 1'b1;
      nclk(1);
      check(pkt_done == 1'b1 && pkt_len == 5'd3, "R5 done len3", pkt_len, 3);
      nclk(1);
      check(pkt_done == 1'b0, "R5 single pulse", pkt_done, 0);
      obuf_expect(0, 8'hA1);
      obuf_expect(1, 8'hA2);
      obuf_expect(2, 8'hA3);
      nclk(DLY + 4);

      // R2 overflow: 18 bytes offered, 16 kept
      for (int i = 0; i < 18; i++) begin
         write_sr(8'(8'h40 + i));
         if (i == 0) host_busy_n = 1'b0;
         else        host_ack_n = ~host_ack_n;
         nclk(1);
      end
      host_busy_n = 1'b1;
      nclk(1);
      check(pkt_done == 1'b1 && pkt_len == 5'd16, "R2 overflow len", pkt_len, 16);
      obuf_expect(0, 8'h40);
      obuf_expect(15, 8'h4F);
      nclk(DLY + 4);
      host_ack_n = 1'b1;
      nclk(DLY + 4);

      // R9 response commit while idle -> request low two edges later
      dir_out = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); rsp_we = 1'b1; rsp_waddr = 4'(i); rsp_wdata = 8'(8'hC0 + i);
      end
      @(negedge clk); rsp_we = 1'b0; rsp_go = 1'b1; rsp_len = 5'd3;
      @(negedge clk); rsp_go = 1'b0;
      @(negedge clk);
      check(dev_req_n == 1'b0, "R9 R6 pending request", dev_req_n, 0);
      nclk(DLY + 2);

      // R3 device-to-host reading
      host_busy_n = 1'b0;
      nclk(1);
      check(sr_q == 8'hC0, "R3 byte0", sr_q, 8'hC0);
      host_ack_n = 1'b0;
      nclk(1);
      check(sr_q == 8'hC1, "R3 byte1", sr_q, 8'hC1);
      host_ack_n = 1'b1;
      nclk(1);
      check(sr_q == 8'hC2 && dev_req_n == 1'b1, "R3 last byte", {dev_req_n, sr_q}, 9'h1C2);
      host_ack_n = 1'b0;
      nclk(1);
      check(sr_q == 8'hC2, "R3 no more bytes", sr_q, 8'hC2);
      host_busy_n = 1'b1;
      nclk(2);
      check(dev_req_n == 1'b1 && pkt_done == 1'b0, "R6 R5 nothing pending", dev_req_n, 1);
      nclk(DLY + 4);

      // R4 idle ack toggles and R7 delay timing
      host_ack_n = 1'b1;
      nclk(1);
      check(dev_req_n == 1'b1, "R4 follow high", dev_req_n, 1);
      nclk(DLY + 4);
      host_ack_n = 1'b0;
      nclk(DLY);
      check(sr_irq == 1'b0, "R7 before delay", sr_irq, 0);
      nclk(1);
      check(sr_irq == 1'b1 && dev_req_n == 1'b0, "R7 R4 at delay", {sr_irq, dev_req_n}, 2);

      // R7 retrigger restarts the delay
      nclk(3);
      host_ack_n = 1'b1;
      nclk(5);
      host_ack_n = 1'b0;
      nclk(DLY);
      check(sr_irq == 1'b0, "R7 restarted", sr_irq, 0);
      nclk(1);
      check(sr_irq == 1'b1, "R7 after restart", sr_irq, 1);
      nclk(4);

      // R8 undelayed interrupt
      hs_dir_mask = 8'hFF;
      host_ack_n = 1'b1;
      nclk(1);
      check(sr_irq == 1'b1, "R8 immediate", sr_irq, 1);
      nclk(1);
      check(sr_irq == 1'b0, "R8 one pulse", sr_irq, 0);
      nclk(DLY + 4);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule